// File: doc/BRIEF.md
# Instruction Length Tracker with Lock-Up Detection

This block watches a byte-wide instruction stream for an 8-bit processor, one byte per valid strobe, and works out where each instruction begins. The first accepted byte after reset is an opcode. It is decoded at once into a total instruction length of 1, 2 or 3 bytes, a no-op flag and a lock-up flag. The block then counts off the operand bytes that follow, so the next opcode is found without any help from downstream logic.

All 256 opcode values are classified, the undefined ones included. Some undefined codes are no-ops that still carry one or two operand bytes, and the block skips those bytes. Twelve undefined codes freeze the processor. When one of them is accepted, the block enters a lock-up state. It ignores every later byte, and only reset clears that state. Typical uses are a trace decoder or a prefetch monitor that must mark opcode boundaries in a captured byte stream.

All outputs are registered. They describe the byte accepted on the previous clock edge.

Top module: `ilt_top`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs become opcode_start=0, operand_index=0, length=1, is_nop=0 and jammed=0 on the next cycle, and the next accepted byte is treated as an opcode.
- R2: One cycle after a byte is accepted as an opcode, opcode_start is 1 and operand_index is 0. In every other cycle opcode_start is 0.
- R3: Each valid byte that arrives while operand bytes remain is treated as an operand, whatever its value. One cycle later operand_index is one higher (1 for the first operand, 2 for the second) and opcode_start is 0. The next valid byte after the last operand is an opcode.
- R4: length gives the total byte count of the current instruction and is set on the opcode cycle. It is 1 for 00, 40, 60, every x8 and xA code, and the lock-up codes. It is 3 for 20, every xC to xF code, and the x9 and xB codes whose upper nibble is odd. Every other code gives 2.
- R5: The codes 80, 82, 89, C2 and E2, and the x4 codes 04, 14, 34, 44, 54, 64, 74, D4 and F4, set is_nop=1 with length 2.
- R6: The codes 0C, 1C, 3C, 5C, 7C, DC and FC set is_nop=1 with length 3.
- R7: The codes 1A, 3A, 5A, 7A, DA, FA and EA set is_nop=1 with length 1. All codes not listed in R5, R6 or R7 set is_nop=0.
- R8: The codes 02, 12, 22, 32, 42, 52, 62, 72, 92, B2, D2 and F2 produce opcode_start=1 and jammed=1 on the next cycle. jammed then stays at 1 until reset, and later bytes change neither opcode_start (held at 0) nor operand_index.
- R9: A cycle with byte_valid low changes no tracking state. opcode_start is 0 in the following cycle.
- R10: After reset clears a lock-up, the first valid byte is decoded as an opcode again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_valid | input | 1 | byte_in carries a stream byte this cycle |
| byte_in | input | 8 | Stream byte |
| opcode_start | output | 1 | Byte accepted last cycle was an opcode |
| operand_index | output | 2 | Position of the last accepted byte within its instruction (0 = opcode) |
| length | output | 2 | Total byte count of the current instruction |
| is_nop | output | 1 | Current instruction has no effect |
| jammed | output | 1 | A lock-up opcode has been seen since reset |

## Verification
If the remaining-operand counter is wrong, the fault shows up on the next valid byte. opcode_start then appears on an operand byte or is missing on an opcode, and from that point every later classification is shifted until the stream happens to realign. A wrong decode for a single code shows up as a bad length or is_nop in the cycle after that opcode, and then as misplaced opcode_start marks once its operands have passed. A lock-up flag that clears without reset, or a jammed block that still advances, shows up on the first byte after the jam code. The bench compares every output against its own model on every clock, so each of these faults is caught within one cycle of its first effect.

// File: rtl/ilt_pkg.sv
// Package: shared types for the instruction length tracker.
// Assumes an 8-bit opcode space with instructions of 1 to 3 bytes.
package ilt_pkg;
    localparam int OP_W  = 8;
    localparam int LEN_W = 2;

    typedef struct packed {
        logic [LEN_W-1:0] len;   // total bytes, 1..3
        logic             nop;   // instruction has no effect
        logic             jam;   // instruction locks the processor
    } op_class_t;
endpackage

// File: rtl/ilt_decode.sv
// Module: ilt_decode
// Purely combinational classifier for one opcode byte. Gives the total
// length, the no-op flag and the lock-up flag for every one of 256 codes.
// Assumes the caller only presents bytes known to be opcodes.
module ilt_decode
    import ilt_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_class_t       cls
);
    logic [3:0] row;
    logic [3:0] col;
    logic       odd_row;

    assign row     = op[7:4];
    assign col     = op[3:0];
    assign odd_row = op[4];

    // Classify the opcode by its column, then refine by row.
    always_comb begin
        cls.jam = (col == 4'h2) && (!op[7] || odd_row);
        cls.nop = 1'b0;
        cls.len = 2'd2;
        unique case (col)
            4'h0: begin
                if (op == 8'h20)
                    cls.len = 2'd3;
                else if (op == 8'h00 || op == 8'h40 || op == 8'h60)
                    cls.len = 2'd1;
                cls.nop = (op == 8'h80);
            end
            4'h2: begin
                cls.len = cls.jam ? 2'd1 : 2'd2;
                cls.nop = (row == 4'h8) || (row == 4'hC) || (row == 4'hE);
            end
            4'h4: cls.nop = row inside {4'h0, 4'h1, 4'h3, 4'h4, 4'h5, 4'h6,
                                        4'h7, 4'hD, 4'hF};
            4'h8: cls.len = 2'd1;
            4'h9: begin
                cls.len = odd_row ? 2'd3 : 2'd2;
                cls.nop = (op == 8'h89);
            end
            4'hA: begin
                cls.len = 2'd1;
                cls.nop = (odd_row && row != 4'h9 && row != 4'hB) || (row == 4'hE);
            end
            4'hB: cls.len = odd_row ? 2'd3 : 2'd2;
            4'hC: begin
                cls.len = 2'd3;
                cls.nop = row inside {4'h0, 4'h1, 4'h3, 4'h5, 4'h7, 4'hD, 4'hF};
            end
            4'hD, 4'hE, 4'hF: cls.len = 2'd3;
            default: cls.len = 2'd2;
        endcase
    end
endmodule

// File: rtl/ilt_track.sv
// Module: ilt_track
// Sequential part: counts remaining operand bytes, registers the class of
// the current instruction and latches the lock-up state.
// Assumes cls is the decode of byte_in; synchronous active-low reset.
module ilt_track
    import ilt_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  op_class_t        cls,
    output logic             opcode_start,
    output logic [IDX_W-1:0] operand_index,
    output logic [LEN_W-1:0] length,
    output logic             is_nop,
    output logic             jammed
);
    logic [IDX_W-1:0] remain_q;
    logic             accept;
    logic             at_opcode;

    assign accept    = byte_valid && !jammed;
    assign at_opcode = (remain_q == '0);

    // Advance the opcode/operand tracking state on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q      <= '0;
            opcode_start  <= 1'b0;
            operand_index <= '0;
            length        <= LEN_W'(1);
            is_nop        <= 1'b0;
            jammed        <= 1'b0;
        end else if (accept && at_opcode) begin
            opcode_start  <= 1'b1;
            operand_index <= '0;
            length        <= cls.len;
            is_nop        <= cls.nop;
            remain_q      <= IDX_W'(cls.len - LEN_W'(1));
            jammed        <= cls.jam;
        end else if (accept) begin
            opcode_start  <= 1'b0;
            operand_index <= operand_index + IDX_W'(1);
            remain_q      <= remain_q - IDX_W'(1);
        end else begin
            opcode_start  <= 1'b0;
        end
    end
endmodule

// File: rtl/ilt_top.sv
// Module: ilt_top
// Instruction length tracker: marks opcodes and operands in a byte stream
// and latches a lock-up state on the jam codes.
// Assumes the first byte after reset is an opcode.
module ilt_top
    import ilt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       opcode_start,
    output logic [1:0] operand_index,
    output logic [1:0] length,
    output logic       is_nop,
    output logic       jammed
);
    op_class_t cls;

    ilt_decode u_decode (
        .op  (byte_in),
        .cls (cls)
    );

    ilt_track #(.IDX_W(2)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_valid    (byte_valid),
        .cls           (cls),
        .opcode_start  (opcode_start),
        .operand_index (operand_index),
        .length        (length),
        .is_nop        (is_nop),
        .jammed        (jammed)
    );
endmodule

// File: rtl/ilt_checker.sv
// Module: ilt_checker
// Protocol properties of the tracker outputs; bound to ilt_top below.
module ilt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid,
    input logic       opcode_start,
    input logic [1:0] operand_index,
    input logic [1:0] length,
    input logic       is_nop,
    input logic       jammed
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!jammed && !opcode_start && operand_index == 2'd0)); // R1

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        opcode_start |-> (operand_index == 2'd0)); // R2

    AST_INDEX_IN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_index < length)); // R3

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (length != 2'd0)); // R4

    AST_JAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        jammed |=> jammed); // R8

    AST_JAM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        jammed |=> (!opcode_start && $stable(operand_index))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_valid && $past(rst_n)) |=> (!opcode_start && $stable(operand_index))); // R9
endmodule

bind ilt_top ilt_checker u_ilt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid    (byte_valid),
    .opcode_start  (opcode_start),
    .operand_index (operand_index),
    .length        (length),
    .is_nop        (is_nop),
    .jammed        (jammed)
);

// File: tb/ilt_top_tb_top.sv
`timescale 1ns/1ps
module ilt_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       opcode_start;
    logic [1:0] operand_index;
    logic [1:0] length;
    logic       is_nop;
    logic       jammed;

    int n_checks = 0;
    int n_errors = 0;

    // behavioural reference state
    int m_rem = 0, m_idx = 0, m_len = 1;
    bit m_start = 0, m_nop = 0, m_jam = 0;

    always #10 clk = ~clk;   // 50 MHz

    ilt_top dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .opcode_start(opcode_start), .operand_index(operand_index),
        .length(length), .is_nop(is_nop), .jammed(jammed)
    );

    function automatic bit ref_jam(int op);
        int jl[$] = '{8'h02, 8'h12, 8'h22, 8'h32, 8'h42, 8'h52,
                      8'h62, 8'h72, 8'h92, 8'hB2, 8'hD2, 8'hF2};
        foreach (jl[i]) if (jl[i] == op) return 1;
        return 0;
    endfunction

    function automatic bit ref_nop(int op);
        int nl[$] = '{8'h80, 8'h82, 8'h89, 8'hC2, 8'hE2,
                      8'h04, 8'h14, 8'h34, 8'h44, 8'h54, 8'h64, 8'h74, 8'hD4, 8'hF4,
                      8'h0C, 8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'hDC, 8'hFC,
                      8'h1A, 8'h3A, 8'h5A, 8'h7A, 8'hDA, 8'hFA, 8'hEA};
        foreach (nl[i]) if (nl[i] == op) return 1;
        return 0;
    endfunction

    function automatic int ref_len(int op);
        int lo = op % 16;
        int hi = op / 16;
        if (ref_jam(op) || op == 8'h00 || op == 8'h40 || op == 8'h60) return 1;
        if (lo == 8 || lo == 10) return 1;
        if (op == 8'h20 || lo >= 12) return 3;
        if ((lo == 9 || lo == 11) && (hi % 2 == 1)) return 3;
        return 2;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare after it
    task automatic step(bit rst, bit v, int b, string tag);
        @(negedge clk);
        rst_n = !rst; byte_valid = v; byte_in = 8'(b);
        @(posedge clk);
        if (rst) begin
            m_rem = 0; m_idx = 0; m_len = 1; m_start = 0; m_nop = 0; m_jam = 0;
        end else if (v && !m_jam) begin
            if (m_rem == 0) begin
                m_start = 1; m_idx = 0; m_len = ref_len(b); m_nop = ref_nop(b);
                m_rem = m_len - 1; m_jam = ref_jam(b);
            end else begin
                m_start = 0; m_idx++; m_rem--;
            end
        end else m_start = 0;
        #1;
        cmp(tag, "opcode_start", opcode_start, m_start);
        cmp(tag, "operand_index", operand_index, m_idx);
        cmp(tag, "length", length, m_len);
        cmp(tag, "is_nop", is_nop, m_nop);
        cmp(tag, "jammed", jammed, m_jam);
    endtask

    task automatic instr(int op, string tag);
        step(0, 1, op, tag);
        // operand bytes use a jam code value: must not be decoded (R3)
        for (int k = 1; k < ref_len(op); k++) step(0, 1, 8'h02, "R3");
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        step(1, 0, 0, "R1");
        step(1, 1, 8'h20, "R1");
        // every non-jam opcode with its operands, idle gaps interleaved
        for (int op = 0; op < 256; op++) begin
            if (ref_jam(op)) continue;
            instr(op, ref_nop(op) ? "R5" : "R4");
            if (op % 7 == 0) step(0, 0, 8'h4C, "R9");
        end
        // no-op groups back to back
        instr(8'h80, "R5"); instr(8'hE2, "R5"); instr(8'hD4, "R5");
        instr(8'h0C, "R6"); step(0, 0, 8'h00, "R9"); instr(8'hFC, "R6");
        instr(8'h1A, "R7"); instr(8'hEA, "R7"); instr(8'hFA, "R7");
        // operand interrupted by idle cycles
        step(0, 1, 8'hAD, "R3"); step(0, 0, 8'h00, "R9");
        step(0, 1, 8'h10, "R3"); step(0, 0, 8'h00, "R9");
        step(0, 1, 8'h20, "R3"); step(0, 1, 8'hE8, "R2");
        // every jam code, then ignored bytes, then reset and recovery
        for (int op = 0; op < 256; op++) begin
            if (!ref_jam(op)) continue;
            instr(8'hA9, "R2");
            step(0, 1, op, "R8");
            step(0, 1, 8'h20, "R8");
            step(0, 0, 8'h00, "R8");
            step(0, 1, 8'hEA, "R8");
            step(1, 0, 0, "R10");
            instr(8'h6D, "R10");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule